// File: doc/BRIEF.md
# Bidirectional Inverting Latched Transceiver

This block sits between two eight-bit ports, A and B, and carries data across in both directions through separate banks of storage. Each direction has three active-low controls of its own: a direction enable, a latch enable and an output enable. Data taken in on one port is held in that direction's bank. It is driven, bit-inverted, onto the opposite port. The two directions share nothing but the clock and reset, so either side can be loaded, held or shown while the other is busy.

Neither port uses a real three-state pin. Each port is a data-in bus plus a data-out bus with a drive-enable flag. When the flag is low the data-out bus reads as all zeros.

The storage is a clocked model of a level-sensitive latch. While a bank is open, its output follows the input in the same cycle through a bypass path. The stored copy is refreshed at each clock edge at which the bank is open. A bank closes when either its direction enable or its latch enable goes high. After that it keeps the value from the last edge at which it was open. A synchronous active-low reset clears both banks to zero.

Top module: `xcvr_inv_latch`

## Requirements
- R1: A clock edge with `rst_n` low clears both banks to zero. After release, a closed bank with its output driven shows all ones on the opposite port.
- R2: With a direction's enable and latch enable both low, the driven output equals the complement of that direction's input in the same cycle, and follows each change of that input.
- R3: When the latch enable goes high, the bank keeps the input value present at the last clock edge at which the bank was open. The output then no longer follows the input.
- R4: When the direction enable goes high while the latch enable is low, the bank likewise keeps the last input sampled while it was open. That value is shown once the enable is lowered again with the latch enable high.
- R5: With the direction enable low and the latch enable high, input changes have no effect on the stored value or on the output.
- R6: A port's drive flag is high exactly when the opposite direction's enable and output enable are both low. While the flag is low, the port's data-out bus is all zeros.
- R7: With the output enable high and both the enable and the latch enable low, the bank still loads while its output stays undriven. The loaded value appears once the output enable is lowered.
- R8: Every driven output bit is the inverse of the corresponding bit of the value passed through the bank (bit i in gives bit i out).
- R9: The A-to-B path (A input, B output) and the B-to-A path (B input, A output) are independent. No control or input of one changes the other's storage or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_din | input | WIDTH | Data entering on port A |
| a_dout | output | WIDTH | Data driven onto port A (B-to-A path) |
| a_drive | output | 1 | Port A drive enable |
| b_din | input | WIDTH | Data entering on port B |
| b_dout | output | WIDTH | Data driven onto port B (A-to-B path) |
| b_drive | output | 1 | Port B drive enable |

## Verification
The hardest case to reach is a bank that was loaded while it could not be observed, either with its output enable high or closed by the direction enable. Its value only shows up later, after the controls have been moved to a held-and-driven setting. Directed sequences load a known pattern out of sight, raise the latch enable before lowering the enable, and then expose the bank. Seeded random control and data changes then run against a bench-side model of both banks. This covers many orderings of enable and latch-enable edges, including short reset pulses.

// File: rtl/xcvr_pkg.sv
// Shared types for the inverting latched transceiver.
// Assumes two directions, indexed by dir_e.
package xcvr_pkg;
    localparam int DIRS = 2;

    typedef enum logic {
        DIR_AB = 1'b0,
        DIR_BA = 1'b1
    } dir_e;

    // Active-low controls belonging to one direction
    typedef struct packed {
        logic en_n;
        logic le_n;
        logic oe_n;
    } ctl_t;
endpackage

// File: rtl/xcvr_latch_bank.sv
// Storage for one direction, modelled as a clocked latch.
// The bank is open when en_n and le_n are both low. While it is open,
// view follows din in the same cycle, and store takes din at each edge.
// Once the bank is closed, view shows the stored value.
// Assumes: rst_n is synchronous and active low.
module xcvr_latch_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xcvr_pkg::ctl_t   ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] view
);
    logic             open_w;
    logic [WIDTH-1:0] store;

    // Open condition: both gating controls low
    always_comb open_w = !ctl.en_n && !ctl.le_n;

    // One storage cell per bit, written only while the bank is open
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[i] <= 1'b0;
            else if (open_w)
                store[i] <= din[i];
        end
    end

    // Output view: bypass while open, stored value otherwise
    always_comb view = open_w ? din : store;

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(ctl.en_n) || $past(ctl.le_n))) |-> $stable(store));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctl.en_n) && !$past(ctl.le_n)) |-> (store == $past(din)));

    // R1
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (store == '0));
endmodule

// File: rtl/xcvr_drive_stage.sv
// Output stage for one direction: inverts the bank view and gates it.
// Drives only when en_n and oe_n are both low. Otherwise the drive
// flag is low and the data bus is held at zero.
// Assumes: purely combinational, no storage.
module xcvr_drive_stage #(
    parameter int WIDTH = 8
) (
    input  xcvr_pkg::ctl_t   ctl,
    input  logic [WIDTH-1:0] view,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);
    // Drive condition and inverted, gated data
    always_comb begin
        drive = !ctl.en_n && !ctl.oe_n;
        dout  = drive ? ~view : '0;
    end
endmodule

// File: rtl/xcvr_path.sv
// One direction of the transceiver: a latch bank followed by a drive stage.
// Assumes: the controls come straight from the block's ports.
module xcvr_path #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xcvr_pkg::ctl_t   ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);
    logic [WIDTH-1:0] view;

    xcvr_latch_bank #(.WIDTH(WIDTH)) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .din   (din),
        .view  (view)
    );

    xcvr_drive_stage #(.WIDTH(WIDTH)) i_drv (
        .ctl   (ctl),
        .view  (view),
        .dout  (dout),
        .drive (drive)
    );
endmodule

// File: rtl/xcvr_inv_latch.sv
// Top level: two independent inverting latched paths between ports A and B.
// The A-to-B path reads a_din and drives b_dout. The B-to-A path reads
// b_din and drives a_dout. Assumes: synchronous active-low reset.
module xcvr_inv_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ab_en_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_en_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n,
    input  logic [WIDTH-1:0] a_din,
    output logic [WIDTH-1:0] a_dout,
    output logic             a_drive,
    input  logic [WIDTH-1:0] b_din,
    output logic [WIDTH-1:0] b_dout,
    output logic             b_drive
);
    import xcvr_pkg::*;

    ctl_t             ctl_arr  [DIRS];
    logic [WIDTH-1:0] din_arr  [DIRS];
    logic [WIDTH-1:0] dout_arr [DIRS];
    logic             drv_arr  [DIRS];

    // Gather each direction's controls and source data
    always_comb begin
        ctl_arr[DIR_AB] = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
        ctl_arr[DIR_BA] = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
        din_arr[DIR_AB] = a_din;
        din_arr[DIR_BA] = b_din;
    end

    // One path per direction
    for (genvar d = 0; d < DIRS; d++) begin : g_dir
        xcvr_path #(.WIDTH(WIDTH)) i_path (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl_arr[d]),
            .din   (din_arr[d]),
            .dout  (dout_arr[d]),
            .drive (drv_arr[d])
        );
    end

    // Route each path to the opposite port
    always_comb begin
        b_dout  = dout_arr[DIR_AB];
        b_drive = drv_arr[DIR_AB];
        a_dout  = dout_arr[DIR_BA];
        a_drive = drv_arr[DIR_BA];
    end

    // R3
    freeze_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && b_drive && ab_le_n && $past(b_drive) && $past(ab_le_n))
        |-> $stable(b_dout));

    // R8
    invert_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drive && !ab_le_n) |-> (b_dout == ~a_din));

    // R8
    invert_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drive && !ba_le_n) |-> (a_dout == ~b_din));

    // R6
    quiet_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_drive |-> a_dout == '0) and (!b_drive |-> b_dout == '0));
endmodule

// File: tb/test_xcvr_inv_latch.sv
// Bench: directed corner cases plus seeded random stimulus,
// compared with a bench-side model of both banks.
module test_xcvr_inv_latch;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic [W-1:0] a_dout, b_dout;
    logic a_drive, b_drive;

    int total = 0;
    int bad = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;

    always #4 clk = ~clk;

    xcvr_inv_latch #(.WIDTH(W)) i_xcvr_inv_latch (
        .clk(clk), .rst_n(rst_n),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
        .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive)
    );

    // Reference storage, updated from the requirements at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ab <= '0;
            m_ba <= '0;
        end else begin
            if (!ab_en_n && !ab_le_n) m_ab <= a_din;
            if (!ba_en_n && !ba_le_n) m_ba <= b_din;
        end
    end

    function automatic logic exp_drv(input logic en_n, input logic oe_n);
        return !en_n && !oe_n;
    endfunction

    function automatic logic [W-1:0] exp_out(input logic en_n, input logic le_n,
        input logic oe_n, input logic [W-1:0] din, input logic [W-1:0] st);
        if (!exp_drv(en_n, oe_n)) return '0;
        return (!le_n) ? ~din : ~st;
    endfunction

    // Compare all outputs a little after the inputs settle, then go to next negedge
    task automatic check(input string req);
        logic [W-1:0] eb, ea;
        logic edb, eda;
        #1;
        eb  = exp_out(ab_en_n, ab_le_n, ab_oe_n, a_din, m_ab);
        ea  = exp_out(ba_en_n, ba_le_n, ba_oe_n, b_din, m_ba);
        edb = exp_drv(ab_en_n, ab_oe_n);
        eda = exp_drv(ba_en_n, ba_oe_n);
        total++;
        if (b_dout !== eb || b_drive !== edb || a_dout !== ea || a_drive !== eda) begin
            bad++;
            $display("FAIL %s: b=%h/%b exp %h/%b a=%h/%b exp %h/%b", req,
                     b_dout, b_drive, eb, edb, a_dout, a_drive, ea, eda);
        end
        @(negedge clk);
    endtask

    initial begin
        #1600000;
        bad++;
        $display("FAIL watchdog: run did not end, expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R6");                // reset, all disabled: nothing driven
        @(negedge clk);
        // R1: release reset, A-to-B closed and driven shows all ones
        rst_n = 1'b1; ab_en_n = 0; ab_le_n = 1; ab_oe_n = 0;
        check("R1");
        // R2/R8: transparent follows complement
        ab_le_n = 0; a_din = 8'h3C; check("R2");
        a_din = 8'h01; check("R8");
        a_din = 8'h3C; check("R2");
        // R3: latch enable rises, output frozen
        ab_le_n = 1; a_din = 8'h55; check("R3");
        // R5: hold while input moves
        a_din = 8'hAA; check("R5");
        a_din = 8'h00; check("R5");
        // R4: close by raising enable
        ab_le_n = 0; a_din = 8'h0F; check("R4");
        ab_en_n = 1; a_din = 8'hF0; check("R6");
        a_din = 8'h77; check("R4");
        ab_le_n = 1; ab_en_n = 0; check("R4");
        // R7: load with output disabled, then expose
        ab_oe_n = 1; ab_le_n = 0; a_din = 8'h81; check("R7");
        ab_le_n = 1; a_din = 8'h42; check("R7");
        ab_oe_n = 0; check("R7");
        // R9: B-to-A transparent and loading while A-to-B holds
        ba_en_n = 0; ba_le_n = 0; ba_oe_n = 0; b_din = 8'h96; check("R9");
        b_din = 8'h69; a_din = 8'hFF; check("R9");
        ba_le_n = 1; b_din = 8'h12; check("R9");
        ab_en_n = 1; check("R9");
        // R1: reset mid-run clears both banks
        ab_en_n = 0; rst_n = 0; check("R1");
        rst_n = 1; check("R1");
        // Random phase
        void'($urandom(32'd1234));
        for (int k = 0; k < 4000; k++) begin
            rst_n   = ($urandom % 64) != 0;
            ab_en_n = ($urandom % 4) == 0;
            ab_le_n = $urandom % 2;
            ab_oe_n = ($urandom % 4) == 0;
            ba_en_n = ($urandom % 4) == 0;
            ba_le_n = $urandom % 2;
            ba_oe_n = ($urandom % 4) == 0;
            a_din   = W'($urandom);
            b_din   = W'($urandom);
            check("R9");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule